// File: doc/BRIEF.md
# External Memory Bus Width Adapter

This block sits between an internal requester and an asynchronous external memory port. The external port can be set to 8, 16 or 32 bits wide. The internal side always presents a 32-bit word address, four byte enables and, for writes, a 32-bit data word. The block turns each request into one or more external device accesses. In the narrow modes it builds the device address by shifting the word address left and filling the freed low bits with a half-word or byte index that it generates itself. This maps each internal word onto 2 or 4 consecutive device locations.

Each external access has fixed timing: one clock of setup, one clock of strobe and one clock of hold. Chip enable stays low through all three phases. Output enable or write enable is low only during the strobe phase. Device locations whose byte lanes carry no active enable are skipped. Read bytes are placed at their own lane positions of the returned word.

The requester holds a request until the one-cycle ready pulse. It then drops or replaces the request. The packed read data stays on its output until the next request begins. The width select is sampled once, when a request is accepted.

Top module: `memWidthAdapter`

## Requirements
- R1: While reset is active and right after its release, extCeN, extOeN and extWeN are high, extDoutEn is low and reqReady is low.
- R2: widthSel code 2 (32-bit) issues one device access whose address is the word address zero-extended by two bits, with no shifting.
- R3: widthSel code 1 (16-bit) uses device address {word address, h}, where h is 0 for bytes 0-1 and 1 for bytes 2-3. The lower half-word is accessed first. Half h is read from and written to lanes [15:0].
- R4: widthSel code 0 (8-bit) uses device address {word address, b} for byte b. Bytes are accessed in ascending order, and each byte travels on lane [7:0].
- R5: A device location is accessed only if one of its bytes is enabled. A request that needs k accesses raises reqReady 3k+1 cycles after the clock edge that accepted it.
- R6: Each access spends exactly one clock with extCeN low and both strobes high, then exactly one clock with the single strobe low (extOeN for reads, extWeN for writes), then one more clock with extCeN low. The two strobes are never low together.
- R7: extBeN is active-low per lane. Reads drive low every lane in use (32-bit: 0000, 16-bit: 1100, 8-bit: 1110). Writes in 32-bit mode drive the inverted byte enables. Writes in 16-bit mode drive {11, inverted enables of the selected half}. Writes in 8-bit mode drive 1110.
- R8: In the returned read word, bytes that are not enabled are zero. Bytes on device lanes that are not in use are ignored.
- R9: reqReady is high for exactly one cycle. rspRdata keeps its value after the pulse.
- R10: widthSel is sampled only when a request is accepted. Changing it during an access leaves that access unchanged. Code 3 behaves as code 2.
- R11: extDoutEn is high during a write access and low during a read access. Unused write lanes are driven with zero.
- R12: A request with all byte enables low makes no device access. It raises reqReady one cycle after acceptance and returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| widthSel | input | 2 | Port width: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| reqValid | input | 1 | Request present, held until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Internal 32-bit word address |
| reqBe | input | 4 | Byte enables, bit i covers byte lane i |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Packed read data |
| extAddr | output | ADDR_W+2 | Device address |
| extCeN | output | 1 | Chip enable, active low |
| extOeN | output | 1 | Output enable, active low |
| extWeN | output | 1 | Write enable, active low |
| extBeN | output | 4 | Lane enables, active low |
| extDout | output | 32 | Write data to device |
| extDoutEn | output | 1 | Drive enable for the data bus |
| extDin | input | 32 | Read data from device |

## Verification
A wrong unit index or mask in the control shows on extAddr during the very next strobe. It also changes the number of strobes, and that moves the reqReady pulse away from the 3k+1 cycle point. A bad lane mux or capture shows only at the end of the request, as a wrong or non-zero byte in rspRdata. A corrupted width register mid-request changes the address format of the following device access, within three cycles.

// File: rtl/memWidthPkg.sv
package memWidthPkg;

  typedef enum logic [1:0] {
    WIDTH8  = 2'd0,
    WIDTH16 = 2'd1,
    WIDTH32 = 2'd2
  } widthE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } stateE;

  typedef struct packed {
    logic       load;
    logic       capture;
    logic       write;
    logic [1:0] unit;
    widthE      width;
  } dpStrobeT;

  function automatic widthE decodeWidth(logic [1:0] sel);
    case (sel)
      2'd0:    return WIDTH8;
      2'd1:    return WIDTH16;
      default: return WIDTH32;
    endcase
  endfunction

  // one bit per device access of a word, set when any of its bytes is enabled
  function automatic logic [3:0] unitMask(widthE w, logic [3:0] be);
    case (w)
      WIDTH8:  return be;
      WIDTH16: return {2'b00, |be[3:2], |be[1:0]};
      default: return {3'b000, |be};
    endcase
  endfunction

  // lowest set unit at or above 'from'; bit 2 set means none left
  function automatic logic [2:0] firstUnit(logic [3:0] mask, logic [2:0] from);
    logic [2:0] r;
    r = 3'b100;
    for (int i = 3; i >= 0; i--) begin
      if (mask[i] && (3'(i) >= from)) r = {1'b0, 2'(i)};
    end
    return r;
  endfunction

  function automatic logic [31:0] byteMask(logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/memWidthCtrl.sv
module memWidthCtrl
  import memWidthPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] widthSel,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [3:0] reqBe,
  output dpStrobeT   stb,
  output logic       ceN,
  output logic       oeN,
  output logic       weN,
  output logic       doutEn,
  output logic       reqReady
);

  stateE      state;
  widthE      widthQ;
  logic [3:0] maskQ;
  logic [1:0] unitQ;
  logic       writeQ;

  widthE      widthNow;
  logic [3:0] maskNow;
  logic [2:0] firstNow;
  logic [2:0] nextAfter;
  logic       accept;
  logic       inAccess;

  always_comb begin
    widthNow  = decodeWidth(widthSel);
    maskNow   = unitMask(widthNow, reqBe);
    firstNow  = firstUnit(maskNow, 3'd0);
    nextAfter = firstUnit(maskQ, {1'b0, unitQ} + 3'd1);
    accept    = (state == ST_IDLE) && reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      widthQ <= WIDTH32;
      maskQ  <= 4'b0;
      unitQ  <= 2'd0;
      writeQ <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            widthQ <= widthNow;
            maskQ  <= maskNow;
            writeQ <= reqWrite;
            if (firstNow[2]) begin
              state <= ST_DONE;
            end else begin
              unitQ <= firstNow[1:0];
              state <= ST_SETUP;
            end
          end
        end
        ST_SETUP:  state <= ST_STROBE;
        ST_STROBE: state <= ST_HOLD;
        ST_HOLD: begin
          if (nextAfter[2]) begin
            state <= ST_DONE;
          end else begin
            unitQ <= nextAfter[1:0];
            state <= ST_SETUP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    inAccess    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    ceN         = !inAccess;
    oeN         = !((state == ST_STROBE) && !writeQ);
    weN         = !((state == ST_STROBE) && writeQ);
    doutEn      = inAccess && writeQ;
    reqReady    = (state == ST_DONE);
    stb.load    = accept;
    stb.capture = (state == ST_STROBE) && !writeQ;
    stb.write   = writeQ;
    stb.unit    = unitQ;
    stb.width   = widthQ;
  end

  // R6: never both strobes
  a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN));
  // R6: strobe only inside chip enable, preceded by a setup cycle
  a_r6_setup_first: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN || !weN) |-> (!ceN && $past(!ceN && oeN && weN)));
  // R6: strobe lasts one clock, followed by hold with chip enable low
  a_r6_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN || !weN) |=> (oeN && weN && !ceN));
  // R3/R4: unit index held through the strobe
  a_r4_unit_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN || !weN) |-> $stable(unitQ));
  // R9: ready is a single-cycle pulse
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);
  // R10: sampled width is frozen while a request is in flight
  a_r10_width_held: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(widthQ));
  // R12: empty request completes without touching the device
  a_r12_empty_request: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqBe == 4'b0) |=> (ceN && reqReady));

endmodule

// File: rtl/memWidthDatapath.sv
module memWidthDatapath
  import memWidthPkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int DEV_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqBe,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       extDin,
  output logic [DEV_W-1:0]  extAddr,
  output logic [3:0]        extBeN,
  output logic [31:0]       extDout,
  output logic [31:0]       rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [3:0]        beQ;
  logic [31:0]       wdataQ;
  logic [31:0]       rdataQ;
  logic [1:0]        halfBe;
  logic [15:0]       halfData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      beQ    <= 4'b0;
      wdataQ <= 32'b0;
      rdataQ <= 32'b0;
    end else if (stb.load) begin
      addrQ  <= reqAddr;
      beQ    <= reqBe;
      wdataQ <= reqWdata;
      rdataQ <= 32'b0;
    end else if (stb.capture) begin
      for (int b = 0; b < 4; b++) begin
        if (beQ[b]) begin
          case (stb.width)
            WIDTH8: begin
              if (2'(b) == stb.unit) rdataQ[8*b +: 8] <= extDin[7:0];
            end
            WIDTH16: begin
              if (1'(b >> 1) == stb.unit[0]) rdataQ[8*b +: 8] <= extDin[8*(b % 2) +: 8];
            end
            default: rdataQ[8*b +: 8] <= extDin[8*b +: 8];
          endcase
        end
      end
    end
  end

  always_comb begin
    halfBe   = stb.unit[0] ? beQ[3:2] : beQ[1:0];
    halfData = stb.unit[0] ? wdataQ[31:16] : wdataQ[15:0];
    case (stb.width)
      WIDTH8: begin
        extAddr = {addrQ, stb.unit};
        extBeN  = 4'b1110;
        extDout = {24'b0, wdataQ[8*stb.unit +: 8]};
      end
      WIDTH16: begin
        extAddr = {1'b0, addrQ, stb.unit[0]};
        extBeN  = {2'b11, stb.write ? ~halfBe : 2'b00};
        extDout = {16'b0, halfData};
      end
      default: begin
        extAddr = {2'b00, addrQ};
        extBeN  = stb.write ? ~beQ : 4'b0000;
        extDout = wdataQ;
      end
    endcase
    rspRdata = rdataQ;
  end

  // R8: bytes outside the request's enables always read back as zero
  a_r8_disabled_bytes_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdataQ & ~byteMask(beQ)) == 32'b0);
  // R9: read data changes only on load or capture
  a_r9_rdata_held: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(stb.load) && !$past(stb.capture)) |-> $stable(rdataQ));

endmodule

// File: rtl/memWidthAdapter.sv
module memWidthAdapter
  import memWidthPkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        widthSel,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqBe,
  input  logic [31:0]       reqWdata,
  output logic              reqReady,
  output logic [31:0]       rspRdata,
  output logic [ADDR_W+1:0] extAddr,
  output logic              extCeN,
  output logic              extOeN,
  output logic              extWeN,
  output logic [3:0]        extBeN,
  output logic [31:0]       extDout,
  output logic              extDoutEn,
  input  logic [31:0]       extDin
);

  dpStrobeT stb;

  memWidthCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .widthSel (widthSel),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqBe    (reqBe),
    .stb      (stb),
    .ceN      (extCeN),
    .oeN      (extOeN),
    .weN      (extWeN),
    .doutEn   (extDoutEn),
    .reqReady (reqReady)
  );

  memWidthDatapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqBe    (reqBe),
    .reqWdata (reqWdata),
    .extDin   (extDin),
    .extAddr  (extAddr),
    .extBeN   (extBeN),
    .extDout  (extDout),
    .rspRdata (rspRdata)
  );

endmodule

// File: tb/memWidthAdapter_tb_top.sv
module memWidthAdapter_tb_top;

  localparam int AW = 20;

  typedef struct packed {
    logic [1:0]    w;
    logic          wr;
    logic [AW-1:0] a;
    logic [3:0]    be;
    logic [31:0]   d;
  } vecT;

  localparam int NV = 13;
  localparam vecT VECS [NV] = '{
    '{2'd2, 1'b0, 20'h00010, 4'hF, 32'h0},
    '{2'd2, 1'b1, 20'h00011, 4'hF, 32'h11223344},
    '{2'd2, 1'b1, 20'h00012, 4'h5, 32'hCAFEF00D},
    '{2'd1, 1'b0, 20'h00123, 4'hF, 32'h0},
    '{2'd1, 1'b1, 20'h00040, 4'hF, 32'hAABBCCDD},
    '{2'd1, 1'b0, 20'h00041, 4'h4, 32'h0},
    '{2'd1, 1'b1, 20'h00042, 4'h2, 32'h99887766},
    '{2'd0, 1'b0, 20'h00777, 4'hF, 32'h0},
    '{2'd0, 1'b1, 20'h00300, 4'hF, 32'h01020304},
    '{2'd0, 1'b0, 20'h00301, 4'hA, 32'h0},
    '{2'd0, 1'b1, 20'h00302, 4'h8, 32'h5566AA77},
    '{2'd3, 1'b0, 20'h00055, 4'h3, 32'h0},
    '{2'd1, 1'b0, 20'h00088, 4'hC, 32'h0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    widthSel = 2'd2;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [3:0]    reqBe = 4'h0;
  logic [31:0]   reqWdata = 32'h0;
  logic          reqReady;
  logic [31:0]   rspRdata;
  logic [AW+1:0] extAddr;
  logic          extCeN, extOeN, extWeN, extDoutEn;
  logic [3:0]    extBeN;
  logic [31:0]   extDout;
  logic [31:0]   extDin;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] devWord(logic [AW+1:0] a);
    return {a[7:0] + 8'h11, a[7:0] ^ 8'h5A, a[7:0] + 8'h77, ~a[7:0]};
  endfunction

  assign extDin = devWord(extAddr);

  memWidthAdapter #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .widthSel(widthSel), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspRdata(rspRdata), .extAddr(extAddr), .extCeN(extCeN),
    .extOeN(extOeN), .extWeN(extWeN), .extBeN(extBeN), .extDout(extDout),
    .extDoutEn(extDoutEn), .extDin(extDin)
  );

  // access log, sampled on falling edges during a strobe
  logic [AW+1:0] logAddr [8];
  logic [3:0]    logBeN  [8];
  logic [31:0]   logDout [8];
  logic          logEn   [8];
  logic          logWe   [8];
  logic          logTimeOk [8];
  int            logN = 0;
  logic          prevCe = 1'b1, prevOe = 1'b1, prevWe = 1'b1;

  always @(negedge clk) begin
    if (!extOeN || !extWeN) begin
      if (logN < 8) begin
        logAddr[logN]   = extAddr;
        logBeN[logN]    = extBeN;
        logDout[logN]   = extDout;
        logEn[logN]     = extDoutEn;
        logWe[logN]     = !extWeN;
        logTimeOk[logN] = !extCeN && !prevCe && prevOe && prevWe && (extOeN || extWeN);
      end
      logN = logN + 1;
    end
    prevCe = extCeN;
    prevOe = extOeN;
    prevWe = extWeN;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOne(input logic [1:0] w, input logic wr, input logic [AW-1:0] a,
                        input logic [3:0] be, input logic [31:0] d, input bit glitch);
    logic [1:0]    ew;
    int            nExp;
    int            units [4];
    logic [31:0]   expR;
    logic [31:0]   gotR;
    int            cyc;
    logic [AW+1:0] eA;
    logic [3:0]    eB;
    logic [31:0]   eD;
    ew = (w == 2'd3) ? 2'd2 : w;
    nExp = 0;
    expR = 32'h0;
    for (int u = 0; u < 4; u++) begin
      bit live;
      case (ew)
        2'd0:    live = be[u];
        2'd1:    live = (u < 2) && (u == 0 ? |be[1:0] : |be[3:2]);
        default: live = (u == 0) && |be;
      endcase
      if (live) begin
        units[nExp] = u;
        nExp++;
      end
    end
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        case (ew)
          2'd0:    expR[8*b +: 8] = devWord({a, 2'(b)}) [7:0];
          2'd1:    expR[8*b +: 8] = devWord({1'b0, a, 1'(b >> 1)}) [8*(b % 2) +: 8];
          default: expR[8*b +: 8] = devWord({2'b00, a}) [8*b +: 8];
        endcase
      end
    end

    @(negedge clk);
    widthSel = w; reqWrite = wr; reqAddr = a; reqBe = be; reqWdata = d;
    reqValid = 1'b1;
    logN = 0;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (glitch && cyc == 2) widthSel = (w == 2'd0) ? 2'd2 : 2'd0;
      if (reqReady || cyc > 200) break;
    end
    gotR = rspRdata;
    reqValid = 1'b0;
    widthSel = w;

    chk(cyc == 3 * nExp + 1, "R5", "ready cycle", 64'(cyc), 64'(3 * nExp + 1));
    chk(logN == nExp, "R5", "access count", 64'(logN), 64'(nExp));
    for (int i = 0; i < nExp && i < logN; i++) begin
      int u;
      u = units[i];
      case (ew)
        2'd0: begin
          eA = {a, 2'(u)};
          eB = 4'b1110;
          eD = {24'h0, d[8*u +: 8]};
        end
        2'd1: begin
          eA = {1'b0, a, 1'(u)};
          eB = wr ? {2'b11, ~be[2*u +: 2]} : 4'b1100;
          eD = {16'h0, d[16*u +: 16]};
        end
        default: begin
          eA = {2'b00, a};
          eB = wr ? ~be : 4'b0000;
          eD = d;
        end
      endcase
      chk(logAddr[i] == eA, (ew == 2'd0) ? "R4" : (ew == 2'd1) ? "R3" : "R2",
          "device address", 64'(logAddr[i]), 64'(eA));
      chk(logBeN[i] == eB, "R7", "lane enables", 64'(logBeN[i]), 64'(eB));
      chk(logTimeOk[i] && logWe[i] == wr, "R6", "strobe phase", 64'(logTimeOk[i]), 64'(1));
      chk(logEn[i] == wr, "R11", "drive enable", 64'(logEn[i]), 64'(wr));
      if (wr) chk(logDout[i] == eD, "R11", "write lanes", 64'(logDout[i]), 64'(eD));
    end
    if (!wr) chk(gotR == expR, glitch ? "R10" : "R8", "read data", 64'(gotR), 64'(expR));

    @(negedge clk);
    chk(!reqReady, "R9", "ready drops", 64'(reqReady), 64'(0));
    chk(rspRdata == gotR, "R9", "read data held", 64'(rspRdata), 64'(gotR));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(extCeN && extOeN && extWeN && !extDoutEn && !reqReady, "R1", "during reset",
        64'({extCeN, extOeN, extWeN, extDoutEn, reqReady}), 64'(5'b11100));
    rstN = 1'b1;
    @(negedge clk);
    chk(extCeN && extOeN && extWeN && !extDoutEn && !reqReady, "R1", "after reset",
        64'({extCeN, extOeN, extWeN, extDoutEn, reqReady}), 64'(5'b11100));

    // vector table
    for (int i = 0; i < NV; i++) begin
      runOne(VECS[i].w, VECS[i].wr, VECS[i].a, VECS[i].be, VECS[i].d, 1'b0);
    end

    // R12: empty request
    runOne(2'd2, 1'b0, 20'h00099, 4'h0, 32'h0, 1'b0);
    runOne(2'd0, 1'b1, 20'h0009A, 4'h0, 32'h12345678, 1'b0);

    // R10: width select changes while an access is in flight
    runOne(2'd1, 1'b0, 20'h00ABC, 4'hF, 32'h0, 1'b1);
    runOne(2'd0, 1'b0, 20'h00ABD, 4'h6, 32'h0, 1'b1);

    // R3: byte read from the 16-bit port returns only that byte
    runOne(2'd1, 1'b0, 20'h00200, 4'h2, 32'h0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule